// File: doc/BRIEF.md
# Multi-way sequential stream buffer

This block sits next to a data cache and holds several short FIFOs. Each FIFO carries one run of consecutive cache-block addresses together with their data. When the cache misses, it presents the block address on the lookup port. The block compares that address with the oldest entry of every FIFO at the same time.

If a head entry matches and its data has already returned from memory, the block answers with a hit and the data in the same cycle, and it removes that entry. If a head entry matches but its data is still in flight, the block answers with a wait and the cache retries later. If no head matches, the block claims a FIFO for a new stream that starts one block past the miss. It takes an unused FIFO first and otherwise the least recently used one.

In the background, the block keeps every claimed FIFO filled. It sends one memory read at a time for the next sequential block, choosing in turn among FIFOs that have a free slot. It sends a read only in cycles with no lookup.

Top module: `seq_stream_buf`

## Requirements
- R1: After reset no FIFO is claimed: `sb_hit`, `sb_wait` and `mreq_valid` are all 0.
- R2: Only the oldest entry of each FIFO takes part in a lookup. An address held deeper in a FIFO gives a miss (`sb_hit`=0, `sb_wait`=0).
- R3: A lookup whose address equals a head entry with returned data gives `sb_hit`=1 and `sb_data` equal to that block's data in the same cycle. The entry is removed, so the next block of the stream becomes the head. `sb_hit` and `sb_wait` are 1 only in a cycle with `miss_valid`=1.
- R4: A lookup whose address equals a head entry whose data has not returned gives `sb_wait`=1 and `sb_hit`=0. The entry stays, and it hits once its data arrives. `sb_hit` and `sb_wait` are never 1 together.
- R5: A lookup that matches no head claims a FIFO. That FIFO then issues reads for the miss address plus 1, 2, 3 and so on in increasing order until it holds DEPTH (4) entries.
- R6: A claim takes the lowest-numbered unused FIFO. When all FIFOs are in use, it recycles the least recently used one and discards that FIFO's old stream.
- R7: Recency is refreshed both when a FIFO is claimed and when a lookup hits at its head.
- R8: At most one memory read is outstanding. `mreq_valid` stays 0 from an accepted read (`mreq_valid` and `mreq_ready` both 1 at a clock edge) until `mrsp_valid` returns its data.
- R9: Reads are granted round-robin among claimed FIFOs that have a free slot. With two such FIFOs, successive reads alternate between their streams.
- R10: No read is issued in a cycle with `miss_valid`=1, and none is issued while every claimed FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_valid | input | 1 | Cache miss lookup this cycle |
| miss_addr | input | AW | Block address of the miss |
| sb_hit | output | 1 | Head hit with data, entry removed |
| sb_wait | output | 1 | Head matched, data not yet returned |
| sb_data | output | DW | Block data on a hit, zero otherwise |
| mreq_valid | output | 1 | Memory read request |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | AW | Block address to read |
| mrsp_valid | input | 1 | Read data returns |
| mrsp_data | input | DW | Returned block data |

## Verification
The assertions take three things for granted about the inputs. Memory answers only a read that it has accepted, it answers each read exactly once, and it never answers with no read outstanding. The cache may hold `miss_valid` high at any time. The bench's memory model accepts a read, returns its data a few cycles later, and holds no second read. It can withhold a response to create the in-flight case. Lookups are driven one per cycle, and between scenarios the bench waits until all FIFOs are full, so every expected outcome follows from the stream state alone.

// File: rtl/sb_pkg.sv
// Shared types for the stream buffer: lookup outcome encoding.
package sb_pkg;
    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_MISS = 2'd1,
        LK_HIT  = 2'd2,
        LK_WAIT = 2'd3
    } lk_kind_e;
endpackage

// File: rtl/sb_fifo.sv
// One stream FIFO: circular store of block address, ready flag and data,
// plus the next block address to fetch. Assumes DEPTH is a power of two,
// that push and pop never coincide with a flush (flush wins), and that a
// fill targets the slot of the single outstanding read.
module sb_fifo #(
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_addr_i,
    input  logic          pop_i,
    input  logic          push_i,
    input  logic          fill_i,
    input  logic [PW-1:0] fill_slot_i,
    input  logic [DW-1:0] fill_data_i,
    output logic          head_vld_o,
    output logic [AW-1:0] head_addr_o,
    output logic          head_rdy_o,
    output logic [DW-1:0] head_data_o,
    output logic          room_o,
    output logic          live_o,
    output logic [AW-1:0] nxt_addr_o,
    output logic [PW-1:0] tail_slot_o
);
    logic [DEPTH-1:0] ent_vld;
    logic [DEPTH-1:0] ent_rdy;
    logic [AW-1:0]    ent_addr [DEPTH];
    logic [DW-1:0]    ent_data [DEPTH];
    logic [PW-1:0]    hd, tl;
    logic [PW:0]      cnt;
    logic             live;
    logic [AW-1:0]    nxt;

    // Control state: claim/flush, pointers, occupancy and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live    <= 1'b0;
            nxt     <= '0;
            hd      <= '0;
            tl      <= '0;
            cnt     <= '0;
            ent_vld <= '0;
            ent_rdy <= '0;
        end else begin
            if (fill_i)
                ent_rdy[fill_slot_i] <= 1'b1;
            if (flush_i) begin
                live    <= 1'b1;
                nxt     <= flush_addr_i + AW'(1);
                hd      <= '0;
                tl      <= '0;
                cnt     <= '0;
                ent_vld <= '0;
            end else begin
                if (pop_i) begin
                    ent_vld[hd] <= 1'b0;
                    hd          <= hd + PW'(1);
                end
                if (push_i) begin
                    ent_vld[tl] <= 1'b1;
                    ent_rdy[tl] <= 1'b0;
                    tl          <= tl + PW'(1);
                    nxt         <= nxt + AW'(1);
                end
                cnt <= cnt + (PW+1)'(push_i) - (PW+1)'(pop_i);
            end
        end
    end

    // Payload storage: address on push, data on fill; no reset needed.
    always_ff @(posedge clk) begin
        if (push_i && !flush_i)
            ent_addr[tl] <= nxt;
        if (fill_i)
            ent_data[fill_slot_i] <= fill_data_i;
    end

    assign head_vld_o  = ent_vld[hd];
    assign head_addr_o = ent_addr[hd];
    assign head_rdy_o  = ent_rdy[hd];
    assign head_data_o = ent_data[hd];
    assign room_o      = live && (cnt < (PW+1)'(DEPTH));
    assign live_o      = live;
    assign nxt_addr_o  = nxt;
    assign tail_slot_o = tl;
endmodule

// File: rtl/sb_lru.sv
// Recency ranking over N FIFOs (rank 0 = most recent) and victim choice:
// lowest-numbered unused FIFO, else the FIFO of rank N-1. Assumes N >= 2.
module sb_lru #(
    parameter int N  = 4,
    localparam int RW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_i,
    input  logic [RW-1:0] touch_id_i,
    input  logic [N-1:0]  live_i,
    output logic [RW-1:0] victim_o
);
    logic [RW-1:0] rank [N];

    // Move the touched FIFO to rank 0 and age those that were more recent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++)
                rank[i] <= RW'(i);
        end else if (touch_i) begin
            for (int i = 0; i < N; i++) begin
                if (RW'(i) == touch_id_i)
                    rank[i] <= '0;
                else if (rank[i] < rank[touch_id_i])
                    rank[i] <= rank[i] + RW'(1);
            end
        end
    end

    // Pick the victim: unused FIFOs first, else the oldest rank.
    always_comb begin
        victim_o = '0;
        for (int i = N-1; i >= 0; i--)
            if (rank[i] == RW'(N-1))
                victim_o = RW'(i);
        for (int i = N-1; i >= 0; i--)
            if (!live_i[i])
                victim_o = RW'(i);
    end
endmodule

// File: rtl/sb_rr_arb.sv
// Round-robin grant among N requesters; the pointer moves past the
// granted one when adv_i is set. Assumes adv_i only when any_o is set.
module sb_rr_arb #(
    parameter int N  = 4,
    localparam int RW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic          adv_i,
    output logic [RW-1:0] grant_o,
    output logic          any_o
);
    logic [RW-1:0] ptr;

    // Search from the pointer upward, wrapping, for the first request.
    always_comb begin
        logic [RW-1:0] idx;
        any_o   = 1'b0;
        grant_o = ptr;
        for (int k = N-1; k >= 0; k--) begin
            idx = RW'((int'(ptr) + k) % N);
            if (req_i[idx]) begin
                any_o   = 1'b1;
                grant_o = idx;
            end
        end
    end

    // Advance the pointer past the served requester.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv_i)
            ptr <= RW'((int'(grant_o) + 1) % N);
    end
endmodule

// File: rtl/seq_stream_buf.sv
// Stream buffer top: parallel head compare, hit/wait/miss outcome, claim
// of a FIFO on a miss, and single-outstanding background refill.
// Assumes memory answers each accepted read exactly once, in order.
module seq_stream_buf
    import sb_pkg::*;
#(
    parameter int AW    = 24,
    parameter int DW    = 32,
    parameter int NBUF  = 4,
    parameter int DEPTH = 4,
    localparam int BW   = $clog2(NBUF),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          miss_valid,
    input  logic [AW-1:0] miss_addr,
    output logic          sb_hit,
    output logic          sb_wait,
    output logic [DW-1:0] sb_data,
    output logic          mreq_valid,
    input  logic          mreq_ready,
    output logic [AW-1:0] mreq_addr,
    input  logic          mrsp_valid,
    input  logic [DW-1:0] mrsp_data
);
    logic [NBUF-1:0] head_vld, head_rdy, room, live, match;
    logic [NBUF-1:0] pop, push, flush, fill;
    logic [AW-1:0]   head_addr [NBUF];
    logic [DW-1:0]   head_data [NBUF];
    logic [AW-1:0]   nxt_addr  [NBUF];
    logic [PW-1:0]   tail_slot [NBUF];

    logic            any_match;
    logic [BW-1:0]   sel, victim, grant;
    lk_kind_e        kind;
    logic            rr_any, req_fire;
    logic            busy;
    logic [BW-1:0]   busy_buf;
    logic [PW-1:0]   busy_slot;

    // Compare the miss with every head; the lowest matching FIFO wins.
    always_comb begin
        any_match = 1'b0;
        sel       = '0;
        for (int i = NBUF-1; i >= 0; i--) begin
            match[i] = miss_valid && head_vld[i] && (head_addr[i] == miss_addr);
            if (match[i]) begin
                any_match = 1'b1;
                sel       = BW'(i);
            end
        end
    end

    // Classify the lookup outcome.
    always_comb begin
        if (!miss_valid)
            kind = LK_NONE;
        else if (!any_match)
            kind = LK_MISS;
        else if (head_rdy[sel])
            kind = LK_HIT;
        else
            kind = LK_WAIT;
    end

    assign sb_hit  = (kind == LK_HIT);
    assign sb_wait = (kind == LK_WAIT);
    assign sb_data = sb_hit ? head_data[sel] : '0;

    // Refill: one read at a time, never in a lookup cycle.
    assign mreq_valid = !busy && !miss_valid && rr_any;
    assign mreq_addr  = nxt_addr[grant];
    assign req_fire   = mreq_valid && mreq_ready;

    // Per-FIFO strobes for pop, claim, push and fill.
    always_comb begin
        for (int i = 0; i < NBUF; i++) begin
            pop[i]   = (kind == LK_HIT)  && (sel == BW'(i));
            flush[i] = (kind == LK_MISS) && (victim == BW'(i));
            push[i]  = req_fire && (grant == BW'(i));
            fill[i]  = mrsp_valid && busy && (busy_buf == BW'(i));
        end
    end

    // Track the single outstanding read and the slot it will fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            busy_buf  <= '0;
            busy_slot <= '0;
        end else if (req_fire) begin
            busy      <= 1'b1;
            busy_buf  <= grant;
            busy_slot <= tail_slot[grant];
        end else if (mrsp_valid) begin
            busy      <= 1'b0;
        end
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        sb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk          (clk),
            .rst_n        (rst_n),
            .flush_i      (flush[g]),
            .flush_addr_i (miss_addr),
            .pop_i        (pop[g]),
            .push_i       (push[g]),
            .fill_i       (fill[g]),
            .fill_slot_i  (busy_slot),
            .fill_data_i  (mrsp_data),
            .head_vld_o   (head_vld[g]),
            .head_addr_o  (head_addr[g]),
            .head_rdy_o   (head_rdy[g]),
            .head_data_o  (head_data[g]),
            .room_o       (room[g]),
            .live_o       (live[g]),
            .nxt_addr_o   (nxt_addr[g]),
            .tail_slot_o  (tail_slot[g])
        );
    end

    sb_lru #(.N(NBUF)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_i    ((kind == LK_HIT) || (kind == LK_MISS)),
        .touch_id_i ((kind == LK_HIT) ? sel : victim),
        .live_i     (live),
        .victim_o   (victim)
    );

    sb_rr_arb #(.N(NBUF)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (room),
        .adv_i   (req_fire),
        .grant_o (grant),
        .any_o   (rr_any)
    );
endmodule

// File: rtl/sb_checker.sv
// Port-level properties of the stream buffer, bound to every instance.
// Assumes memory responds only to an accepted read.
module sb_checker #(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          miss_valid,
    input logic [AW-1:0] miss_addr,
    input logic          sb_hit,
    input logic          sb_wait,
    input logic [DW-1:0] sb_data,
    input logic          mreq_valid,
    input logic          mreq_ready,
    input logic [AW-1:0] mreq_addr,
    input logic          mrsp_valid,
    input logic [DW-1:0] mrsp_data
);
    logic outstanding;

    // Mirror of the read handshake: set on accept, cleared on response.
    always_ff @(posedge clk) begin
        if (!rst_n)
            outstanding <= 1'b0;
        else if (mreq_valid && mreq_ready)
            outstanding <= 1'b1;
        else if (mrsp_valid)
            outstanding <= 1'b0;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!mreq_valid && !sb_hit && !sb_wait));

    a_r8_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mreq_valid);

    a_r10_no_req_in_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> !mreq_valid);

    a_r3_answer_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_hit || sb_wait) |-> miss_valid);

    a_r4_hit_wait_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sb_hit && sb_wait));

    a_r3_data_zero_off_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !sb_hit |-> (sb_data == '0));
endmodule

bind seq_stream_buf sb_checker #(.AW(AW), .DW(DW)) u_sb_checker (.*);

// File: tb/test_seq_stream_buf.sv
// Scoreboard bench: lookup tasks queue expected outcomes, a monitor pops
// and compares them; a memory model answers reads and logs addresses.
module test_seq_stream_buf;
    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          sb_hit, sb_wait;
    logic [DW-1:0] sb_data;
    logic          mreq_valid;
    logic          mreq_ready = 1'b1;
    logic [AW-1:0] mreq_addr;
    logic          mrsp_valid = 1'b0;
    logic [DW-1:0] mrsp_data = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    seq_stream_buf #(.AW(AW), .DW(DW)) i_seq_stream_buf (.*);

    always #2 clk = ~clk;

    function automatic logic [DW-1:0] blk_data(input logic [AW-1:0] a);
        return {a[7:0], a} ^ 32'h5A3C_96E1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected lookup outcome: 0 miss, 1 hit, 2 wait.
    typedef struct {
        int            kind;
        logic [AW-1:0] addr;
        string         req;
    } exp_t;
    exp_t sbq[$];

    // Memory model state.
    logic [AW-1:0] req_log[$];
    bit            hold = 1'b0;
    bit            pend = 1'b0;
    int            pend_cnt = 0;
    logic [AW-1:0] pend_addr = '0;

    task automatic lookup(input logic [AW-1:0] a, input int kind, input string req);
        exp_t e;
        @(negedge clk);
        miss_valid = 1'b1;
        miss_addr  = a;
        e.kind = kind;
        e.addr = a;
        e.req  = req;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        miss_valid = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: compare each lookup cycle with the head of the scoreboard.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && miss_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R3", "unexpected lookup", 0, 1);
            end else begin
                exp_t e;
                int act;
                e = sbq.pop_front();
                act = sb_hit ? 1 : (sb_wait ? 2 : 0);
                check(act == e.kind, e.req, $sformatf("outcome addr %0h", e.addr),
                      act, e.kind);
                if (e.kind == 1)
                    check(sb_data == blk_data(e.addr), e.req, "hit data",
                          sb_data, blk_data(e.addr));
            end
        end
    end

    // Memory model: one read in flight, answered after a short delay.
    always begin
        @(negedge clk);
        mrsp_valid = 1'b0;
        if (pend) begin
            if (pend_cnt > 0)
                pend_cnt--;
            else if (!hold) begin
                mrsp_valid = 1'b1;
                mrsp_data  = blk_data(pend_addr);
                pend       = 1'b0;
            end
        end
        #1;
        if (rst_n && mreq_valid && mreq_ready) begin
            req_log.push_back(mreq_addr);
            pend      = 1'b1;
            pend_cnt  = 2;
            pend_addr = mreq_addr;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        #1;
        check(!sb_hit && !sb_wait && !mreq_valid, "R1", "outputs in reset",
              {sb_hit, sb_wait, mreq_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!mreq_valid && req_log.size() == 0, "R1", "no read after reset",
              req_log.size(), 0);

        // R5: first miss claims FIFO 0 and fetches the next four blocks.
        lookup(24'h000100, 0, "R5");
        idle(40);
        check(req_log.size() == 4, "R5", "read count", req_log.size(), 4);
        for (int k = 0; k < 4; k++)
            if (k < req_log.size())
                check(req_log[k] == 24'h000101 + AW'(k), "R5", "read order",
                      req_log[k], 24'h000101 + AW'(k));

        // R3: head hits pop in stream order.
        lookup(24'h000101, 1, "R3");
        lookup(24'h000102, 1, "R3");
        // R2: 0x104 sits behind head 0x103, so it misses (claims FIFO 1).
        lookup(24'h000104, 0, "R2");
        idle(60);

        // R4: hold the response so the head stays in flight.
        hold = 1'b1;
        lookup(24'h000300, 0, "R6");
        idle(8);
        lookup(24'h000301, 2, "R4");
        lookup(24'h000301, 2, "R4");
        idle(2);
        hold = 1'b0;
        idle(60);
        lookup(24'h000301, 1, "R4");
        lookup(24'h000400, 0, "R6");
        idle(60);

        // R7: a hit on FIFO 0 refreshes it, so FIFO 1 is the one recycled.
        lookup(24'h000103, 1, "R7");
        lookup(24'h000500, 0, "R6");
        idle(60);
        lookup(24'h000105, 0, "R6");
        idle(60);
        lookup(24'h000104, 1, "R7");
        lookup(24'h000401, 1, "R6");
        lookup(24'h000501, 1, "R6");
        lookup(24'h000106, 1, "R5");
        lookup(24'h000302, 0, "R6");
        idle(60);

        // R9: two fresh streams share the bus alternately.
        req_log.delete();
        lookup(24'h000800, 0, "R9");
        lookup(24'h000900, 0, "R9");
        idle(80);
        check(req_log.size() == 8, "R9", "read count", req_log.size(), 8);
        if (req_log.size() == 8) begin
            for (int k = 1; k < 8; k++)
                check(req_log[k][11:8] != req_log[k-1][11:8], "R9", "alternation",
                      req_log[k], req_log[k-1]);
            for (int k = 0; k < 6; k++)
                check(req_log[k+2] == req_log[k] + AW'(1), "R9", "stream order",
                      req_log[k+2], req_log[k] + AW'(1));
        end

        // R10: with every claimed FIFO full, no read goes out.
        n0 = req_log.size();
        idle(20);
        #1;
        check(req_log.size() == n0 && !mreq_valid, "R10", "idle bus when full",
              req_log.size(), n0);

        check(sbq.size() == 0, "R3", "scoreboard drained", sbq.size(), 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule